// File: doc/BRIEF.md
# IDE LBA Sector Transfer Sequencer

This block drives a 16-bit IDE/ATA register bus through one complete single-sector operation in 28-bit LBA mode, using programmed I/O and status polling. The host gives it a request: read a sector, write a sector or identify the device, with a 28-bit block address and a drive select bit. The sequencer then performs each register access in turn through a request/acknowledge port that carries a 4-bit register index, a direction and data. It waits on the status register between phases and moves the sector's 16-bit words through valid/ready streams: towards the host for reads and identify, and from the host for writes.

When the operation finishes, the block raises a one-cycle completion pulse. Alongside the pulse it reports whether the device signalled an error, a write fault or a polling timeout. On an error it also returns the contents of the device's error register. Every status wait has a cycle limit that the host sets, so a device that never becomes ready cannot hang the block.

Top module: `ide_lba_seq`

## Requirements
- R1: A request on `op_valid` is taken only while `op_ready` is high, and the block latches kind, address and select at that edge. While an operation is running, `op_valid` and changes on the request fields have no effect on the register accesses it makes.
- R2: The first accesses of every operation are reads of register 7. They repeat until a status has bit 7 (busy) at 0 and bit 6 (ready) at 1, and no write comes before that.
- R3: Register 6 is written with bits 7:5 set to 1, bit 4 set to the drive select (0 master, 1 slave) and bits 3:0 set to address bits 27:24. For identify, bits 3:0 are written as 0.
- R4: For read and write, the order of writes after the drive select is: register 3 gets address bits 7:0, register 4 gets bits 15:8, register 5 gets bits 23:16, register 2 gets 1, and then the command goes to register 7.
- R5: For identify, only register 6 and then the command are written. Registers 2 to 5 are not touched.
- R6: The command byte is 0x20 for read (op_kind 0, and also 3), 0x30 for write (op_kind 1) and 0xEC for identify (op_kind 2).
- R7: After the command, register 7 is polled until busy is 0 and bit 3 (data request) is 1. Read and identify then read register 0 exactly SECTOR_WORDS times and present each word in order on `rd_data`, with the word held until `rd_ready`.
- R8: A write takes SECTOR_WORDS words from `wr_data` in order and writes each one to register 0. It then polls register 7 until busy is 0 and ready is 1 before it checks for errors.
- R9: When a non-busy status read in the data-request wait or the final write wait has bit 0 (error) set, the block skips any remaining data phase. It reads register 1 and completes with `done_err` set and `err_code` equal to that byte.
- R10: When bit 5 (device fault) is set in a non-busy status, the block completes with `done_wfault` set. If error is clear, it completes without reading register 1 and without moving data.
- R11: When a status wait lasts `poll_limit` cycles without success, the operation ends with `done_tmo` set, `done_err` and `done_wfault` clear, and no access other than status reads.
- R12: A register request holds its index, direction and data until acknowledged, and is withdrawn early only on a timeout. `done` is high for exactly one cycle, after which `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_limit | input | TMO_W | Cycle limit for each status wait |
| op_valid | input | 1 | Start request |
| op_ready | output | 1 | Block idle, request accepted this cycle if valid |
| op_kind | input | 2 | 0 read, 1 write, 2 identify, 3 read |
| op_lba | input | 28 | Sector address |
| op_slave | input | 1 | Drive select, 1 for slave |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 for register write |
| reg_idx | output | 4 | Register index |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access done, read data valid |
| reg_rdata | input | 16 | Read data |
| rd_valid | output | 1 | Sector word available |
| rd_ready | input | 1 | Host takes the sector word |
| rd_data | output | 16 | Sector word to the host |
| wr_valid | input | 1 | Host offers a sector word |
| wr_ready | output | 1 | Block takes the sector word |
| wr_data | input | 16 | Sector word from the host |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Device reported an error |
| done_tmo | output | 1 | A status wait timed out |
| done_wfault | output | 1 | Device reported a fault |
| err_code | output | 8 | Error register contents |

## Verification
The bench builds the block with SECTOR_WORDS at 256 and TMO_W at 10, so each transfer moves a full sector, in the same word count a real device expects. The timeout limit is a port, so a limit of a few tens of cycles makes the start-of-operation and data-request timeouts expire quickly. Random status busy counts, acknowledge latencies and stream stalls then sit well under a generous limit. A bus model in the bench returns scripted status bytes, including busy statuses with the error and data-request bits set, and it logs every access, so the order of all register accesses is compared against a sequence the bench computes.

// File: rtl/ide_seq_pkg.sv
// Package: shared encodings for the IDE LBA sequencer.
// Assumes a task-file register bus with a 4-bit index (0..7 command block).
package ide_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_IDENT = 2'd2,
        OP_READX = 2'd3
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_SEL,
        ST_LBA0,
        ST_LBA1,
        ST_LBA2,
        ST_CNT,
        ST_CMD,
        ST_WAIT_DRQ,
        ST_RD_FETCH,
        ST_RD_PUSH,
        ST_WR_PULL,
        ST_WR_STORE,
        ST_WAIT_FIN,
        ST_ERR_FETCH,
        ST_END
    } seq_state_e;

    localparam logic [3:0] RIX_DATA    = 4'd0;
    localparam logic [3:0] RIX_ERROR   = 4'd1;
    localparam logic [3:0] RIX_COUNT   = 4'd2;
    localparam logic [3:0] RIX_LBA0    = 4'd3;
    localparam logic [3:0] RIX_LBA1    = 4'd4;
    localparam logic [3:0] RIX_LBA2    = 4'd5;
    localparam logic [3:0] RIX_DRVHD   = 4'd6;
    localparam logic [3:0] RIX_CMDSTAT = 4'd7;

    localparam int SB_ERR = 0;
    localparam int SB_DRQ = 3;
    localparam int SB_DF  = 5;
    localparam int SB_RDY = 6;
    localparam int SB_BSY = 7;

    localparam logic [7:0] CMD_READ  = 8'h20;
    localparam logic [7:0] CMD_WRITE = 8'h30;
    localparam logic [7:0] CMD_IDENT = 8'hEC;

    // Drive/head byte: fixed ones, select bit, top address nibble.
    function automatic logic [7:0] drive_head(input logic slave, input logic [3:0] hi);
        return {3'b111, slave, hi};
    endfunction

    // Command byte for an operation kind; kind 3 behaves as read.
    function automatic logic [7:0] cmd_code(input op_kind_e kind);
        case (kind)
            OP_WRITE: return CMD_WRITE;
            OP_IDENT: return CMD_IDENT;
            default:  return CMD_READ;
        endcase
    endfunction

endpackage

// File: rtl/ide_poll_timer.sv
// Module: cycle counter for status waits.
// Counts cycles while 'active' is high and clears whenever it is low; the
// count saturates. Assumes two wait phases are never back to back.
module ide_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    // Count cycles spent in the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != {TMO_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry once the wait has lasted the limit.
    always_comb begin
        expired = active && (cnt_q >= limit);
    end
endmodule

// File: rtl/ide_word_counter.sv
// Module: sector word counter.
// Steps once per moved word and flags the last word of a sector.
// Assumes WORDS is at least 2.
module ide_word_counter #(
    parameter int WORDS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(WORDS);
    localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

    logic [CW-1:0] cnt_q;

    // Word index within the sector.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Final word of the sector.
    always_comb begin
        last = (cnt_q == LAST_IDX);
    end
endmodule

// File: rtl/ide_status_eval.sv
// Module: decodes a status byte into the conditions the sequencer waits on.
// Assumes the other bits are meaningless while busy is set, so every
// condition requires busy clear.
module ide_status_eval (
    input  logic [7:0] status,
    output logic       ready_ok,
    output logic       drq_ok,
    output logic       has_err,
    output logic       has_df
);
    import ide_seq_pkg::*;

    // Condition decode, all gated by busy clear.
    always_comb begin
        ready_ok = !status[SB_BSY] && status[SB_RDY];
        drq_ok   = !status[SB_BSY] && status[SB_DRQ];
        has_err  = !status[SB_BSY] && status[SB_ERR];
        has_df   = !status[SB_BSY] && status[SB_DF];
    end
endmodule

// File: rtl/ide_lba_seq.sv
// Module: IDE single-sector LBA28 PIO sequencer (top).
// Runs read, write or identify: ready poll, drive/address/count setup,
// command, data-request poll, 16-bit data phase, final poll for writes,
// error register fetch. Assumes a register port that keeps reg_ack low
// except for one cycle per finished access, with reg_rdata valid then.
module ide_lba_seq #(
    parameter int SECTOR_WORDS = 256,
    parameter int TMO_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] poll_limit,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [1:0]       op_kind,
    input  logic [27:0]      op_lba,
    input  logic             op_slave,
    output logic             reg_req,
    output logic             reg_we,
    output logic [3:0]       reg_idx,
    output logic [15:0]      reg_wdata,
    input  logic             reg_ack,
    input  logic [15:0]      reg_rdata,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [15:0]      rd_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [15:0]      wr_data,
    output logic             done,
    output logic             done_err,
    output logic             done_tmo,
    output logic             done_wfault,
    output logic [7:0]       err_code
);
    import ide_seq_pkg::*;

    seq_state_e  state_q, state_d;
    op_kind_e    kind_q;
    logic [27:0] lba_q;
    logic        slave_q;
    logic [15:0] word_q;
    logic [7:0]  err_code_q;
    logic        err_q, tmo_q, wf_q;

    logic latch_op, take_rd, take_wr, step, set_tmo, set_wf, set_err;
    logic in_wait, tmo_hit, last_word;
    logic st_ready_ok, st_drq_ok, st_err, st_df;

    ide_poll_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_wait),
        .limit   (poll_limit),
        .expired (tmo_hit)
    );

    ide_word_counter #(.WORDS(SECTOR_WORDS)) u_words (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE),
        .step  (step),
        .last  (last_word)
    );

    ide_status_eval u_stat (
        .status   (reg_rdata[7:0]),
        .ready_ok (st_ready_ok),
        .drq_ok   (st_drq_ok),
        .has_err  (st_err),
        .has_df   (st_df)
    );

    // Wait phases that run the timeout counter.
    always_comb begin
        in_wait = (state_q == ST_WAIT_RDY) || (state_q == ST_WAIT_DRQ) ||
                  (state_q == ST_WAIT_FIN);
    end

    // Next-state and action strobes of the sequencer.
    always_comb begin
        state_d  = state_q;
        latch_op = 1'b0;
        take_rd  = 1'b0;
        take_wr  = 1'b0;
        step     = 1'b0;
        set_tmo  = 1'b0;
        set_wf   = 1'b0;
        set_err  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    latch_op = 1'b1;
                    state_d  = ST_WAIT_RDY;
                end
            end
            ST_WAIT_RDY: begin
                if (reg_ack) begin
                    if (st_ready_ok) state_d = ST_SEL;
                end else if (tmo_hit) begin
                    set_tmo = 1'b1;
                    state_d = ST_END;
                end
            end
            ST_SEL: begin
                if (reg_ack) state_d = (kind_q == OP_IDENT) ? ST_CMD : ST_LBA0;
            end
            ST_LBA0: if (reg_ack) state_d = ST_LBA1;
            ST_LBA1: if (reg_ack) state_d = ST_LBA2;
            ST_LBA2: if (reg_ack) state_d = ST_CNT;
            ST_CNT:  if (reg_ack) state_d = ST_CMD;
            ST_CMD:  if (reg_ack) state_d = ST_WAIT_DRQ;
            ST_WAIT_DRQ: begin
                if (reg_ack) begin
                    if (st_err) begin
                        set_wf  = st_df;
                        state_d = ST_ERR_FETCH;
                    end else if (st_df) begin
                        set_wf  = 1'b1;
                        state_d = ST_END;
                    end else if (st_drq_ok) begin
                        state_d = (kind_q == OP_WRITE) ? ST_WR_PULL : ST_RD_FETCH;
                    end
                end else if (tmo_hit) begin
                    set_tmo = 1'b1;
                    state_d = ST_END;
                end
            end
            ST_RD_FETCH: begin
                if (reg_ack) begin
                    take_rd = 1'b1;
                    state_d = ST_RD_PUSH;
                end
            end
            ST_RD_PUSH: begin
                if (rd_ready) begin
                    step    = 1'b1;
                    state_d = last_word ? ST_END : ST_RD_FETCH;
                end
            end
            ST_WR_PULL: begin
                if (wr_valid) begin
                    take_wr = 1'b1;
                    state_d = ST_WR_STORE;
                end
            end
            ST_WR_STORE: begin
                if (reg_ack) begin
                    step    = 1'b1;
                    state_d = last_word ? ST_WAIT_FIN : ST_WR_PULL;
                end
            end
            ST_WAIT_FIN: begin
                if (reg_ack) begin
                    if (st_ready_ok) begin
                        set_wf  = st_df;
                        state_d = st_err ? ST_ERR_FETCH : ST_END;
                    end
                end else if (tmo_hit) begin
                    set_tmo = 1'b1;
                    state_d = ST_END;
                end
            end
            ST_ERR_FETCH: begin
                if (reg_ack) begin
                    set_err = 1'b1;
                    state_d = ST_END;
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Register port drive for the current state.
    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_idx   = RIX_CMDSTAT;
        reg_wdata = 16'h0000;
        case (state_q)
            ST_WAIT_RDY, ST_WAIT_DRQ, ST_WAIT_FIN: begin
                reg_req = 1'b1;
                reg_idx = RIX_CMDSTAT;
            end
            ST_SEL: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_DRVHD;
                reg_wdata = {8'h00, drive_head(slave_q,
                             (kind_q == OP_IDENT) ? 4'h0 : lba_q[27:24])};
            end
            ST_LBA0: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_LBA0;
                reg_wdata = {8'h00, lba_q[7:0]};
            end
            ST_LBA1: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_LBA1;
                reg_wdata = {8'h00, lba_q[15:8]};
            end
            ST_LBA2: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_LBA2;
                reg_wdata = {8'h00, lba_q[23:16]};
            end
            ST_CNT: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_COUNT;
                reg_wdata = 16'h0001;
            end
            ST_CMD: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_CMDSTAT;
                reg_wdata = {8'h00, cmd_code(kind_q)};
            end
            ST_RD_FETCH: begin
                reg_req = 1'b1;
                reg_idx = RIX_DATA;
            end
            ST_WR_STORE: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = RIX_DATA;
                reg_wdata = word_q;
            end
            ST_ERR_FETCH: begin
                reg_req = 1'b1;
                reg_idx = RIX_ERROR;
            end
            default: begin
                reg_req = 1'b0;
            end
        endcase
    end

    // Sequencer state, request capture, data word and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            kind_q     <= OP_READ;
            lba_q      <= '0;
            slave_q    <= 1'b0;
            word_q     <= '0;
            err_code_q <= '0;
            err_q      <= 1'b0;
            tmo_q      <= 1'b0;
            wf_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (latch_op) begin
                kind_q     <= op_kind_e'(op_kind);
                lba_q      <= op_lba;
                slave_q    <= op_slave;
                err_code_q <= '0;
                err_q      <= 1'b0;
                tmo_q      <= 1'b0;
                wf_q       <= 1'b0;
            end
            if (take_rd) word_q <= reg_rdata;
            if (take_wr) word_q <= wr_data;
            if (set_tmo) tmo_q <= 1'b1;
            if (set_wf)  wf_q  <= 1'b1;
            if (set_err) begin
                err_q      <= 1'b1;
                err_code_q <= reg_rdata[7:0];
            end
        end
    end

    // Host-side outputs.
    always_comb begin
        op_ready    = (state_q == ST_IDLE);
        rd_valid    = (state_q == ST_RD_PUSH);
        rd_data     = word_q;
        wr_ready    = (state_q == ST_WR_PULL);
        done        = (state_q == ST_END);
        done_err    = err_q;
        done_tmo    = tmo_q;
        done_wfault = wf_q;
        err_code    = err_code_q;
    end
endmodule

// File: rtl/ide_lba_seq_chk.sv
// Checker: port-level properties of the IDE sequencer, bound to every instance.
module ide_lba_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_ready,
    input logic        reg_req,
    input logic        reg_we,
    input logic [3:0]  reg_idx,
    input logic [15:0] reg_wdata,
    input logic        reg_ack,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [15:0] rd_data,
    input logic        wr_ready,
    input logic        done,
    input logic        done_err,
    input logic        done_tmo,
    input logic        done_wfault
);
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> (reg_req && $stable(reg_idx) && $stable(reg_we) &&
                                 $stable(reg_wdata)) || done_tmo); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && op_ready); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !reg_req && !rd_valid && !wr_ready); // R1
    AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready && !done |=> !op_ready); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R7
    AST_TMO_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_tmo |-> !done_err && !done_wfault); // R11
endmodule

bind ide_lba_seq ide_lba_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_ready    (op_ready),
    .reg_req     (reg_req),
    .reg_we      (reg_we),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .reg_ack     (reg_ack),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .wr_ready    (wr_ready),
    .done        (done),
    .done_err    (done_err),
    .done_tmo    (done_tmo),
    .done_wfault (done_wfault)
);

// File: tb/sim_ide_lba_seq.sv
`timescale 1ns/1ps
// Bench: register-bus device model with access log, random and directed operations.
module sim_ide_lba_seq;
    localparam int WORDS = 256;
    localparam int TW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] poll_limit = TW'(200);
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [1:0]    op_kind = 2'd0;
    logic [27:0]   op_lba = '0;
    logic          op_slave = 1'b0;
    logic          reg_req, reg_we, reg_ack = 1'b0;
    logic [3:0]    reg_idx;
    logic [15:0]   reg_wdata, reg_rdata = '0;
    logic          rd_valid, rd_ready = 1'b0;
    logic [15:0]   rd_data;
    logic          wr_valid = 1'b0, wr_ready;
    logic [15:0]   wr_data = '0;
    logic          done, done_err, done_tmo, done_wfault;
    logic [7:0]    err_code;

    always #4 clk = ~clk;

    ide_lba_seq #(.SECTOR_WORDS(WORDS), .TMO_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .poll_limit(poll_limit),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_lba(op_lba), .op_slave(op_slave),
        .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .done(done), .done_err(done_err), .done_tmo(done_tmo),
        .done_wfault(done_wfault), .err_code(err_code)
    );

    int n_chk = 0;
    int n_err = 0;

    // Device model configuration and access log.
    int          busy_left = 0, post_cfg = 0, fin_cfg = 0, lat_cfg = 0;
    int          wait_cnt = 0, phase = 0, rd_ptr = 0;
    logic [7:0]  drq_stat = 8'h58, fin_stat = 8'h50, err_val = 8'h04;
    logic [27:0] cur_lba = '0;
    logic [20:0] log_q [0:1023];
    int          log_n = 0;
    logic [20:0] exp_q [0:1023];
    int          exp_n = 0;

    function automatic logic [15:0] drv_word(input logic [27:0] lba, input int i);
        logic [31:0] t;
        t = {4'h0, lba} * 32'd2654435 + 32'(i) * 32'd40503;
        return t[15:0] ^ t[31:16];
    endfunction

    function automatic logic [15:0] host_word(input int s, input int i);
        logic [31:0] t;
        t = 32'(s) * 32'd69069 + 32'(i) * 32'd1103515;
        return t[15:0] ^ t[31:16];
    endfunction

    // Register-bus responder: acknowledges after lat_cfg cycles and logs.
    always @(posedge clk) begin
        reg_ack <= 1'b0;
        if (!rst_n) begin
            wait_cnt = 0;
        end else if (reg_req && !reg_ack) begin
            if (wait_cnt > 0) begin
                wait_cnt = wait_cnt - 1;
            end else begin
                reg_ack <= 1'b1;
                wait_cnt = lat_cfg;
                if (log_n < 1024) begin
                    log_q[log_n] = {reg_we, reg_idx, reg_we ? reg_wdata : 16'h0};
                    log_n = log_n + 1;
                end
                if (reg_we) begin
                    reg_rdata <= 16'h0;
                    if (reg_idx == 4'd7) begin
                        phase = 1;
                        busy_left = post_cfg;
                    end else if (reg_idx == 4'd0 && phase == 1) begin
                        phase = 2;
                        busy_left = fin_cfg;
                    end
                end else begin
                    case (reg_idx)
                        4'd7: begin
                            if (busy_left > 0) begin
                                busy_left = busy_left - 1;
                                reg_rdata <= 16'h0089;
                            end else if (phase == 0) reg_rdata <= 16'h0050;
                            else if (phase == 1) reg_rdata <= {8'h0, drq_stat};
                            else reg_rdata <= {8'h0, fin_stat};
                        end
                        4'd0: begin
                            reg_rdata <= drv_word(cur_lba, rd_ptr);
                            rd_ptr = rd_ptr + 1;
                        end
                        4'd1: reg_rdata <= {8'h0, err_val};
                        default: reg_rdata <= 16'h0;
                    endcase
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic we, input logic [3:0] idx, input logic [15:0] d);
        exp_q[exp_n] = {we, idx, d};
        exp_n++;
    endtask

    // mode: 0 normal, 1 ERR at data request, 2 DF at data request,
    //       3 ERR at final write poll, 4 timeout after command, 5 timeout at start
    task automatic build_exp(input int kind, input logic [27:0] lba, input logic sl,
                             input int pre, input int post, input int fin,
                             input int mode, input int seed);
        exp_n = 0;
        if (mode == 5) return;
        for (int i = 0; i <= pre; i++) push_exp(1'b0, 4'd7, 16'h0);
        push_exp(1'b1, 4'd6, {8'h0, 3'b111, sl, (kind == 2) ? 4'h0 : lba[27:24]});
        if (kind != 2) begin
            push_exp(1'b1, 4'd3, {8'h0, lba[7:0]});
            push_exp(1'b1, 4'd4, {8'h0, lba[15:8]});
            push_exp(1'b1, 4'd5, {8'h0, lba[23:16]});
            push_exp(1'b1, 4'd2, 16'h0001);
        end
        push_exp(1'b1, 4'd7, (kind == 1) ? 16'h0030 : (kind == 2) ? 16'h00EC : 16'h0020);
        if (mode == 4) return;
        for (int i = 0; i <= post; i++) push_exp(1'b0, 4'd7, 16'h0);
        if (mode == 1) begin
            push_exp(1'b0, 4'd1, 16'h0);
        end else if (mode != 2) begin
            if (kind == 1) begin
                for (int i = 0; i < WORDS; i++) push_exp(1'b1, 4'd0, host_word(seed, i));
                for (int i = 0; i <= fin; i++) push_exp(1'b0, 4'd7, 16'h0);
                if (mode == 3) push_exp(1'b0, 4'd1, 16'h0);
            end else begin
                for (int i = 0; i < WORDS; i++) push_exp(1'b0, 4'd0, 16'h0);
            end
        end
    endtask

    task automatic run_op(input int kind, input logic [27:0] lba, input logic sl,
                          input int pre, input int post, input int fin, input int lat,
                          input int mode, input int seed, input bit ign, input string tag);
        int rd_cnt = 0, wr_cnt = 0, rd_bad = 0, cyc = 0, lead = 0;
        bit got = 0, pv = 0, pr = 0, pwr = 0, pwv = 0, seq_ok = 1;
        logic [7:0] ev;
        ev = 8'(($urandom % 255) + 1);
        @(negedge clk);
        busy_left = (mode == 5) ? 1000000 : pre;
        post_cfg  = (mode == 4) ? 1000000 : post;
        fin_cfg = fin; lat_cfg = lat; phase = 0; rd_ptr = 0; log_n = 0;
        cur_lba = lba; err_val = ev;
        drq_stat = (mode == 1) ? 8'h49 : (mode == 2) ? 8'h68 : 8'h58;
        fin_stat = (mode == 3) ? 8'h51 : 8'h50;
        build_exp(kind, lba, sl, pre, post, fin, mode, seed);
        check(op_ready == 1'b1, "R1", {tag, " ready before start"}, 32'(op_ready), 1);
        op_kind = 2'(kind); op_lba = lba; op_slave = sl; op_valid = 1'b1;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (pv && pr) begin
                if (rd_data_q != drv_word(lba, rd_cnt)) rd_bad++;
                rd_cnt++;
            end
            if (pwr && pwv) wr_cnt++;
            if (done) begin got = 1; cyc = c; break; end
            if (ign && c >= 40 && c < 52) begin
                op_valid = 1'b1; op_kind = 2'd1; op_lba = ~lba; op_slave = ~sl;
            end else begin
                op_valid = 1'b0; op_kind = 2'(kind); op_lba = lba; op_slave = sl;
            end
            rd_ready = ($urandom % 4) != 0;
            wr_valid = ($urandom % 3) != 0;
            wr_data  = host_word(seed, wr_cnt);
            pv = rd_valid; pr = rd_ready; pwr = wr_ready; pwv = wr_valid;
            rd_data_q = rd_data;
        end
        op_valid = 1'b0; rd_ready = 1'b0; wr_valid = 1'b0;
        check(got, "R12", {tag, " done seen"}, 32'(got), 1);
        // Sequence comparison against the computed access list.
        if (mode >= 4) begin
            if (log_n < exp_n) seq_ok = 0;
            for (int i = 0; i < log_n && i < 1024; i++) begin
                if (i < exp_n) begin
                    if (log_q[i] != exp_q[i]) seq_ok = 0;
                end else if (log_q[i] != {1'b0, 4'd7, 16'h0}) seq_ok = 0;
            end
        end else begin
            if (log_n != exp_n) seq_ok = 0;
            for (int i = 0; i < exp_n && i < log_n; i++)
                if (log_q[i] != exp_q[i]) seq_ok = 0;
        end
        check(seq_ok, tag, "access sequence (length)", 32'(log_n), 32'(exp_n));
        if (mode != 5) begin
            while (lead < log_n && log_q[lead] == {1'b0, 4'd7, 16'h0}) lead++;
            check(lead == pre + 1, "R2", {tag, " leading status polls"}, 32'(lead), 32'(pre + 1));
            check(log_q[pre + 1] == exp_q[pre + 1], "R3", {tag, " drive/head write"},
                  32'(log_q[pre + 1]), 32'(exp_q[pre + 1]));
            check(log_q[pre + ((kind == 2) ? 2 : 6)] == exp_q[pre + ((kind == 2) ? 2 : 6)],
                  "R6", {tag, " command write"}, 32'(log_q[pre + ((kind == 2) ? 2 : 6)]),
                  32'(exp_q[pre + ((kind == 2) ? 2 : 6)]));
        end
        if (mode == 0 && kind != 1) begin
            check(rd_cnt == WORDS && rd_bad == 0, "R7", {tag, " words streamed out"},
                  32'(rd_cnt), WORDS);
        end else begin
            check(rd_cnt == 0, (mode >= 4) ? "R11" : "R9", {tag, " no data streamed"},
                  32'(rd_cnt), 0);
        end
        if (mode == 0 && kind == 1)
            check(wr_cnt == WORDS, "R8", {tag, " words taken"}, 32'(wr_cnt), WORDS);
        check(done_err == (mode == 1 || mode == 3), "R9", {tag, " error flag"},
              32'(done_err), 32'(mode == 1 || mode == 3));
        if (mode == 1 || mode == 3)
            check(err_code == ev, "R9", {tag, " error code"}, 32'(err_code), 32'(ev));
        check(done_wfault == (mode == 2), "R10", {tag, " fault flag"},
              32'(done_wfault), 32'(mode == 2));
        check(done_tmo == (mode >= 4), "R11", {tag, " timeout flag"},
              32'(done_tmo), 32'(mode >= 4));
        if (mode == 5)
            check(cyc >= int'(poll_limit) && cyc <= int'(poll_limit) + 6, "R11",
                  {tag, " timeout latency"}, 32'(cyc), 32'(poll_limit));
        @(negedge clk);
        check(!done && op_ready, "R12", {tag, " single done pulse"}, 32'({done, op_ready}), 1);
    endtask

    logic [15:0] rd_data_q = '0;
    int          cyc_all = 0;

    // Watchdog: a hung run still reports.
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc_all);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed0;
        seed0 = int'($urandom(32'h1D5E));
        repeat (5) @(negedge clk);
        check(op_ready && !reg_req && !rd_valid && !wr_ready && !done, "R1",
              "reset state", 32'({op_ready, reg_req, rd_valid, wr_ready, done}), 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_ready && !done_err && !done_tmo && !done_wfault, "R12", "after reset",
              32'({op_ready, done_err, done_tmo, done_wfault}), 32'h8);
        // Directed corner cases.
        run_op(0, 28'hABCDEF1, 1'b0, 0, 0, 0, 0, 0, 11, 0, "R4");
        run_op(1, 28'h0123456, 1'b1, 2, 1, 2, 1, 0, 12, 0, "R8");
        run_op(2, 28'hFFFFFFF, 1'b1, 1, 2, 0, 2, 0, 13, 0, "R5");
        run_op(3, 28'h8000001, 1'b0, 0, 1, 0, 0, 0, 14, 0, "R6");
        run_op(0, 28'h1111111, 1'b1, 3, 0, 0, 1, 0, 15, 1, "R1");
        run_op(0, 28'h2222222, 1'b0, 1, 1, 0, 0, 1, 16, 0, "R9");
        run_op(1, 28'h3333333, 1'b0, 0, 0, 1, 1, 3, 17, 0, "R9");
        run_op(2, 28'h4444444, 1'b1, 0, 1, 0, 0, 2, 18, 0, "R10");
        poll_limit = TW'(25);
        run_op(0, 28'h5555555, 1'b0, 0, 0, 0, 0, 5, 19, 0, "R11");
        run_op(1, 28'h6666666, 1'b1, 0, 0, 0, 1, 4, 20, 0, "R11");
        poll_limit = TW'(200);
        // Random operations.
        for (int k = 0; k < 8; k++) begin
            int kd;
            kd = int'($urandom % 4);
            run_op(kd, 28'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 4),
                   int'($urandom % 3), int'($urandom % 3), 0, 100 + k, 0,
                   (kd == 1) ? "R8" : (kd == 2) ? "R5" : "R4");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule